// File: doc/BRIEF.md
# Top-of-Memory Chip-Select Decoder

This block turns a 20-bit processor byte address into active-low chip enables for eight 4 KiB memory devices. The devices sit in the highest 32 KiB of the 1 MiB space. The low twelve address bits go to every device unchanged. Three middle bits pick the device. The five top bits must all be ones before any enable can fire. A status input tells memory cycles apart from IO cycles, and an IO cycle never selects a device.

The read and write strobes from the processor are gated into an active-low output enable and an active-low write enable for the device that is selected. The two can never be active together. The block also reports the number of the selected device and a valid flag, so that the memory map can be checked at the ports. It is purely combinational and holds no state.

Top module: `memdec_top`

## Requirements
- R1: `dev_addr_o` always equals `addr_i[11:0]`, whatever the cycle type, strobes or window match.
- R2: For a memory cycle (`mem_io_i`=1) with `addr_i[19:15]` all ones, exactly `ce_n_o[k]` is 0, where k = `addr_i[14:12]`. All other bits of `ce_n_o` are 1.
- R3: If any of `addr_i[19:15]` is 0, all bits of `ce_n_o` are 1 and `hit_vld_o` is 0.
- R4: In an IO cycle (`mem_io_i`=0), all bits of `ce_n_o` are 1 and `hit_vld_o` is 0, even inside the window.
- R5: At most one bit of `ce_n_o` is 0. `hit_vld_o` is 1 exactly when one bit of `ce_n_o` is 0.
- R6: `hit_idx_o` is `{1'b0, addr_i[14:12]}` when `hit_vld_o` is 1, and 4'd0 otherwise.
- R7: `oe_n_o` is 0 only when `rd_n_i`=0, `wr_n_i`=1 and a chip enable is active. Otherwise it is 1.
- R8: `we_n_o` is 0 only when `wr_n_i`=0, `rd_n_i`=1 and a chip enable is active. Otherwise it is 1.
- R9: `oe_n_o` and `we_n_o` are never both 0. When both strobes are 0 at once, both outputs stay 1.
- R10: Device k covers byte addresses 0xF8000+k·0x1000 through 0xF8FFF+k·0x1000, for k = 0 to 7, in ascending order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 20 | Processor byte address |
| mem_io_i | input | 1 | 1 = memory cycle, 0 = IO cycle |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| ce_n_o | output | 8 | Per-device chip enables, active low, bit k = device k |
| oe_n_o | output | 1 | Output enable to the selected device, active low |
| we_n_o | output | 1 | Write enable to the selected device, active low |
| dev_addr_o | output | 12 | Byte offset inside the device |
| hit_idx_o | output | 4 | Number of the selected device, 0 when there is no hit |
| hit_vld_o | output | 1 | 1 when some device is selected |

## Verification
The bench uses the package defaults: a 20-bit address, eight devices and 4 KiB per device. These values put the whole window at 0xF8000–0xFFFFF. The bench reaches both edges of every device range, the addresses just below the window and with the top bit cleared, IO cycles inside the window, and the clash case where both strobes are low. A further run of pseudo-random addresses, cycle types and strobes covers mixed patterns, with the top address bits forced high often enough to land inside the window.

// File: rtl/memdec_pkg.sv
package memdec_pkg;
    parameter int ADDR_W   = 20;
    parameter int DEV_CNT  = 8;
    parameter int DEV_LOG2 = 12;

    localparam int SEL_W  = $clog2(DEV_CNT);
    localparam int IDX_W  = SEL_W + 1;
    localparam int TAG_LO = DEV_LOG2 + SEL_W;
    localparam int TAG_W  = ADDR_W - TAG_LO;

    typedef struct packed {
        logic             hit;
        logic [SEL_W-1:0] sel;
    } dec_t;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_CLASH = 2'd3
    } acc_e;

    // True when the tag field of the address is all ones (top-of-memory window)
    function automatic logic tag_match(input logic [ADDR_W-1:0] a);
        return &a[ADDR_W-1:TAG_LO];
    endfunction

    function automatic acc_e classify(input logic rd_n, input logic wr_n);
        case ({rd_n, wr_n})
            2'b01:   return ACC_READ;
            2'b10:   return ACC_WRITE;
            2'b00:   return ACC_CLASH;
            default: return ACC_IDLE;
        endcase
    endfunction
endpackage

// File: rtl/memdec_window.sv
module memdec_window
    import memdec_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              mem_io_i,
    output dec_t              dec_o
);
    always_comb begin
        dec_o.hit = mem_io_i && tag_match(addr_i);
        dec_o.sel = addr_i[TAG_LO-1:DEV_LOG2];
    end
endmodule

// File: rtl/memdec_onehot.sv
module memdec_onehot
    import memdec_pkg::*;
(
    input  dec_t               dec_i,
    output logic [DEV_CNT-1:0] ce_n_o,
    output logic               any_o
);
    for (genvar k = 0; k < DEV_CNT; k++) begin : g_ce
        assign ce_n_o[k] = !(dec_i.hit && (dec_i.sel == SEL_W'(k)));
    end
    assign any_o = ~&ce_n_o;
endmodule

// File: rtl/memdec_strobe.sv
module memdec_strobe
    import memdec_pkg::*;
(
    input  logic rd_n_i,
    input  logic wr_n_i,
    input  logic sel_i,
    output logic oe_n_o,
    output logic we_n_o
);
    acc_e kind;

    always_comb begin
        kind   = classify(rd_n_i, wr_n_i);
        oe_n_o = 1'b1;
        we_n_o = 1'b1;
        if (sel_i) begin
            unique case (kind)
                ACC_READ:  oe_n_o = 1'b0;
                ACC_WRITE: we_n_o = 1'b0;
                default: begin
                    oe_n_o = 1'b1;
                    we_n_o = 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/memdec_top.sv
module memdec_top
    import memdec_pkg::*;
(
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                mem_io_i,
    input  logic                rd_n_i,
    input  logic                wr_n_i,
    output logic [DEV_CNT-1:0]  ce_n_o,
    output logic                oe_n_o,
    output logic                we_n_o,
    output logic [DEV_LOG2-1:0] dev_addr_o,
    output logic [IDX_W-1:0]    hit_idx_o,
    output logic                hit_vld_o
);
    dec_t dec;
    logic any_sel;

    memdec_window u_win (
        .addr_i   (addr_i),
        .mem_io_i (mem_io_i),
        .dec_o    (dec)
    );

    memdec_onehot u_oh (
        .dec_i  (dec),
        .ce_n_o (ce_n_o),
        .any_o  (any_sel)
    );

    memdec_strobe u_stb (
        .rd_n_i (rd_n_i),
        .wr_n_i (wr_n_i),
        .sel_i  (any_sel),
        .oe_n_o (oe_n_o),
        .we_n_o (we_n_o)
    );

    assign dev_addr_o = addr_i[DEV_LOG2-1:0];
    assign hit_vld_o  = any_sel;
    assign hit_idx_o  = any_sel ? {1'b0, dec.sel} : '0;
endmodule

// File: rtl/memdec_chk.sv
module memdec_chk
    import memdec_pkg::*;
(
    input logic [ADDR_W-1:0]  addr_i,
    input logic               mem_io_i,
    input logic               rd_n_i,
    input logic               wr_n_i,
    input logic [DEV_CNT-1:0] ce_n_o,
    input logic               oe_n_o,
    input logic               we_n_o,
    input logic [IDX_W-1:0]   hit_idx_o,
    input logic               hit_vld_o
);
    always_comb begin
        AST_CE_ONEHOT: assert ($onehot0(~ce_n_o)); // R5
        AST_VLD_MATCHES_CE: assert (hit_vld_o == !(&ce_n_o)); // R5
        if (hit_vld_o) begin
            AST_IDX_POINTS_CE: assert (ce_n_o[hit_idx_o[SEL_W-1:0]] == 1'b0); // R2
        end
        if (!(&addr_i[ADDR_W-1:TAG_LO])) begin
            AST_OUT_OF_WINDOW: assert (&ce_n_o && !hit_vld_o); // R3
        end
        if (!mem_io_i) begin
            AST_IO_QUIET: assert (&ce_n_o && !hit_vld_o); // R4
        end
        if (!oe_n_o) begin
            AST_OE_QUAL: assert (!rd_n_i && wr_n_i && !(&ce_n_o)); // R7
        end
        if (!we_n_o) begin
            AST_WE_QUAL: assert (!wr_n_i && rd_n_i && !(&ce_n_o)); // R8
        end
        AST_OE_WE_EXCL: assert (oe_n_o || we_n_o); // R9
    end
endmodule

bind memdec_top memdec_chk u_chk (
    .addr_i    (addr_i),
    .mem_io_i  (mem_io_i),
    .rd_n_i    (rd_n_i),
    .wr_n_i    (wr_n_i),
    .ce_n_o    (ce_n_o),
    .oe_n_o    (oe_n_o),
    .we_n_o    (we_n_o),
    .hit_idx_o (hit_idx_o),
    .hit_vld_o (hit_vld_o)
);

// File: tb/memdec_top_test.sv
`timescale 1ns/1ps
module memdec_top_test;
    import memdec_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [ADDR_W-1:0]   addr;
    logic                mem_io;
    logic                rd_n;
    logic                wr_n;
    logic [DEV_CNT-1:0]  ce_n;
    logic                oe_n;
    logic                we_n;
    logic [DEV_LOG2-1:0] dev_addr;
    logic [IDX_W-1:0]    hit_idx;
    logic                hit_vld;

    memdec_top uut (
        .addr_i     (addr),
        .mem_io_i   (mem_io),
        .rd_n_i     (rd_n),
        .wr_n_i     (wr_n),
        .ce_n_o     (ce_n),
        .oe_n_o     (oe_n),
        .we_n_o     (we_n),
        .dev_addr_o (dev_addr),
        .hit_idx_o  (hit_idx),
        .hit_vld_o  (hit_vld)
    );

    typedef struct {
        string               req;
        logic [DEV_CNT-1:0]  ce_n;
        logic                oe_n;
        logic                we_n;
        logic [DEV_LOG2-1:0] dev_addr;
        logic [IDX_W-1:0]    idx;
        logic                vld;
    } exp_t;

    exp_t exp_q[$];
    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    // Independent model of the requirements
    task automatic drive(input logic [19:0] a, input logic mio,
                         input logic r_n, input logic w_n, input string req);
        exp_t e;
        logic inwin;
        int   dev;
        @(posedge clk);
        addr = a; mem_io = mio; rd_n = r_n; wr_n = w_n;
        inwin = mio && (a >= 20'hF8000);          // R10 window
        dev   = inwin ? int'((a - 20'hF8000) / 20'h1000) : 0;
        e.req      = req;
        e.ce_n     = inwin ? ~(8'h01 << dev) : 8'hFF;
        e.vld      = inwin;
        e.idx      = inwin ? 4'(dev) : 4'd0;
        e.dev_addr = a[11:0];
        e.oe_n     = !(inwin && !r_n && w_n);
        e.we_n     = !(inwin && !w_n && r_n);
        exp_q.push_back(e);
    endtask

    task automatic cmp(input string req, input string fld,
                       input logic [31:0] got, input logic [31:0] want);
        n_run++;
        if (got !== want) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, fld, got, want);
        end
    endtask

    // Monitor: compares away from the driving edge
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                cmp({e.req, "/R1"}, "dev_addr", 32'(dev_addr), 32'(e.dev_addr));
                cmp({e.req, "/R2"}, "ce_n",     32'(ce_n),     32'(e.ce_n));
                cmp({e.req, "/R5"}, "hit_vld",  32'(hit_vld),  32'(e.vld));
                cmp({e.req, "/R6"}, "hit_idx",  32'(hit_idx),  32'(e.idx));
                cmp({e.req, "/R7"}, "oe_n",     32'(oe_n),     32'(e.oe_n));
                cmp({e.req, "/R8"}, "we_n",     32'(we_n),     32'(e.we_n));
                cmp({e.req, "/R9"}, "oe_we_excl", 32'(oe_n | we_n), 32'd1);
            end
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        addr = '0; mem_io = 1'b0; rd_n = 1'b1; wr_n = 1'b1;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Idle state after reset: IO cycle, no strobes
        drive(20'h00000, 1'b0, 1'b1, 1'b1, "RST_R4");
        // R10: both ends of each device range, read then write
        for (int k = 0; k < DEV_CNT; k++) begin
            drive(20'hF8000 + 20'(k) * 20'h1000, 1'b1, 1'b0, 1'b1, "R10_lo");
            drive(20'hF8FFF + 20'(k) * 20'h1000, 1'b1, 1'b1, 1'b0, "R10_hi");
        end
        // R3: just below the window, top bit clear
        drive(20'hF7FFF, 1'b1, 1'b0, 1'b1, "R3_below");
        drive(20'h7C123, 1'b1, 1'b1, 1'b0, "R3_a19");
        drive(20'h00000, 1'b1, 1'b0, 1'b1, "R3_zero");
        // R4: IO cycle inside the window
        drive(20'hFC555, 1'b0, 1'b0, 1'b1, "R4_io");
        drive(20'hFFFFF, 1'b0, 1'b1, 1'b0, "R4_io");
        // R9: both strobes low in the window
        drive(20'hFA010, 1'b1, 1'b0, 1'b0, "R9_clash");
        // R7/R8: selected device, no strobe
        drive(20'hFD800, 1'b1, 1'b1, 1'b1, "R7_idle");
        // Mixed pseudo-random patterns, biased toward the window
        for (int i = 0; i < 200; i++) begin
            logic [19:0] a;
            logic [2:0]  s;
            a = 20'($urandom);
            if (i % 2 == 0) a[19:15] = 5'h1F;
            s = 3'($urandom);
            drive(a, s[0] | s[2], s[1], ~s[1] ^ s[2], "R2_rand");
        end
        @(posedge clk);
        while (exp_q.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule